// File: doc/BRIEF.md
# Multiplexed Parallel Result Read Port

This block puts an 18-bit conversion result onto a host's parallel bus whose width the host picks. A new result arrives with a one-cycle load strobe and is copied into a holding register. The host then reads it with chip select and read strobe both low. Two address inputs choose which slice of the held sample is driven.

The 2-bit mode input sets the bus width. In full-width mode all 18 bits appear at once. In word mode the result is split into a high word and a low word. In byte mode it is split into a high, a mid and a low byte. Serial mode keeps the parallel bus released. A slice is always driven on the top pins of the bus. The read scheme is the same whichever side starts a conversion.

Tri-state is modelled with a per-pin output enable. A pin whose enable is low also drives zero on the data output. Because the held copy changes only on a load, a read that takes several bus cycles returns slices of one sample.

Top module: `par_result_port`

## Requirements
- R1: After reset the holding register is zero, so a full-width read returns 0.
- R2: The holding register takes `res_in` on a clock edge where `res_load` is high, and keeps its value on every other edge, whatever `res_in` does in between.
- R3: Unless `cs_n` and `rd_n` are both low, `bus_oe` is all zeros.
- R4: With mode 0 and a read active, all 18 pins are enabled and `bus_out` equals the held result; `addr` has no effect.
- R5: With mode 1, a read active and `addr[0]`=0, pins 17..2 are enabled and carry held bits 17..2; pins 1..0 are disabled.
- R6: With mode 1, a read active and `addr[0]`=1, pins 17..2 carry held bits 1..0 on pins 17..16 with zeros on pins 15..2; `addr[1]` has no effect in mode 1.
- R7: With mode 2 and a read active, only pins 17..10 are enabled. For `addr` = 0, 1 and 2 they carry held bits 17..10, held bits 9..2, and held bits 1..0 on pins 17..16 with zeros below. For `addr` = 3 they carry all zeros.
- R8: With mode 3, `bus_oe` is all zeros for every other input.
- R9: Every pin whose enable is low drives 0 on `bus_out`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| mode | input | 2 | 0 full width, 1 word, 2 byte, 3 serial (bus released) |
| cs_n | input | 1 | Chip select, active low |
| rd_n | input | 1 | Read strobe, active low |
| addr | input | 2 | Slice select |
| res_in | input | 18 | New conversion result |
| res_load | input | 1 | Capture `res_in` at this edge |
| bus_out | output | 18 | Parallel bus data |
| bus_oe | output | 18 | Per-pin output enable (low models high impedance) |

## Verification
The hardest case to reach is a new result loaded in the middle of a multi-cycle word or byte read. Only there does the holding register decide whether the host sees a consistent sample. The stimulus starts a byte read, changes `res_in` on every cycle without a load, and then pulses `res_load` between the mid and low byte reads. A reference model that updates its copy only on load edges shows whether the bus switched exactly at that edge. The stimulus also sweeps every mode, address and strobe combination over patterns with distinct top and bottom bits, so that a swapped slice or a wrong pin offset shows up.

// File: rtl/par_result_port.sv
module par_result_port #(
  parameter int RES_W  = 18,
  parameter int BYTE_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       mode,
  input  logic             cs_n,
  input  logic             rd_n,
  input  logic [1:0]       addr,
  input  logic [RES_W-1:0] res_in,
  input  logic             res_load,
  output logic [RES_W-1:0] bus_out,
  output logic [RES_W-1:0] bus_oe
);
  localparam int WORD_W = RES_W - 2;
  localparam int TAIL_W = RES_W - WORD_W;
  localparam int WPAD   = RES_W - WORD_W;
  localparam int BPAD   = RES_W - BYTE_W;

  logic [RES_W-1:0]  hold;
  logic [WORD_W-1:0] word_sel;
  logic [BYTE_W-1:0] byte_sel;
  logic              rd_act;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)        hold <= '0;
    else if (res_load) hold <= res_in;

  assign rd_act = !cs_n && !rd_n;

  assign word_sel = addr[0] ? {hold[TAIL_W-1:0], {(WORD_W-TAIL_W){1'b0}}}
                            : hold[RES_W-1 -: WORD_W];

  always_comb
    case (addr)
      2'd0:    byte_sel = hold[RES_W-1 -: BYTE_W];
      2'd1:    byte_sel = hold[RES_W-1-BYTE_W -: BYTE_W];
      2'd2:    byte_sel = {hold[TAIL_W-1:0], {(BYTE_W-TAIL_W){1'b0}}};
      default: byte_sel = '0;
    endcase

  always_comb begin
    bus_out = '0;
    bus_oe  = '0;
    if (rd_act)
      case (mode)
        2'd0: begin
          bus_out = hold;
          bus_oe  = '1;
        end
        2'd1: begin
          bus_out = {word_sel, {WPAD{1'b0}}};
          bus_oe  = {{WORD_W{1'b1}}, {WPAD{1'b0}}};
        end
        2'd2: begin
          bus_out = {byte_sel, {BPAD{1'b0}}};
          bus_oe  = {{BYTE_W{1'b1}}, {BPAD{1'b0}}};
        end
        default: ;
      endcase
  end

  a_r2_capture: assert property (@(posedge clk) disable iff (!rst_n)
    res_load |=> hold == $past(res_in));
  a_r2_keep: assert property (@(posedge clk) disable iff (!rst_n)
    !res_load |=> $stable(hold));
  a_r3_released: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_n || rd_n) |-> bus_oe == '0);
  a_r8_serial_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    mode == 2'd3 |-> bus_oe == '0);
  a_r9_idle_pins_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_out & ~bus_oe) == '0);
  a_r4_full_width: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_act && mode == 2'd0) |-> bus_out == hold);
endmodule

// File: tb/test_par_result_port.sv
module test_par_result_port;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  mode = 2'd0;
  logic        cs_n = 1'b1;
  logic        rd_n = 1'b1;
  logic [1:0]  addr = 2'd0;
  logic [17:0] res_in = '0;
  logic        res_load = 1'b0;
  logic [17:0] bus_out, bus_oe;

  int checks = 0;
  int failures = 0;
  bit running = 0;
  int ref_hold = 0;

  always #2.5 clk = ~clk;

  par_result_port i_par_result_port (
    .clk(clk), .rst_n(rst_n), .mode(mode), .cs_n(cs_n), .rd_n(rd_n),
    .addr(addr), .res_in(res_in), .res_load(res_load),
    .bus_out(bus_out), .bus_oe(bus_oe));

  always @(posedge clk)
    if (!rst_n) ref_hold = 0;
    else if (res_load) ref_hold = int'(res_in);

  task automatic expect_bus(output int d, output int e, output string tag);
    int h = ref_hold;
    d = 0; e = 0;
    if (cs_n || rd_n) begin tag = "R3"; return; end
    case (mode)
      2'd0: begin tag = "R4"; d = h; e = 'h3FFFF; end
      2'd1: begin
        tag = addr[0] ? "R6" : "R5";
        d = addr[0] ? ((h & 3) << 14) << 2 : (h >> 2) << 2;
        e = 'h3FFFC;
      end
      2'd2: begin
        tag = "R7";
        e = 'h3FC00;
        if (addr == 0)      d = ((h >> 10) & 255) << 10;
        else if (addr == 1) d = ((h >> 2) & 255) << 10;
        else if (addr == 2) d = ((h & 3) << 6) << 10;
        else                d = 0;
      end
      default: tag = "R8";
    endcase
  endtask

  always @(negedge clk)
    if (running) begin
      int d, e;
      string tag;
      expect_bus(d, e, tag);
      checks++;
      if (int'(bus_oe) != e || int'(bus_out) != d) begin
        failures++;
        $display("FAIL %s/R9 mode=%0d addr=%0d oe=%05h exp %05h data=%05h exp %05h",
                 tag, mode, addr, bus_oe, e, bus_out, d);
      end
    end

  task automatic cyc(input logic [1:0] m, input logic c, input logic r,
                     input logic [1:0] a, input logic [17:0] v, input logic ld);
    @(posedge clk); #1;
    mode = m; cs_n = c; rd_n = r; addr = a; res_in = v; res_load = ld;
  endtask

  task automatic named(input string tag, input logic [17:0] exp_v);
    @(negedge clk);
    checks++;
    if (bus_out !== exp_v) begin
      failures++;
      $display("FAIL %s data=%05h exp %05h", tag, bus_out, exp_v);
    end
  endtask

  initial begin
    logic [17:0] pats [8] = '{18'h3FFFF, 18'h00000, 18'h2AAAA, 18'h15555,
                              18'h30001, 18'h00003, 18'h1C3A6, 18'h20002};
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    running = 1;
    cyc(0, 0, 0, 3, 18'h12345, 0);
    named("R1", 18'h0);
    cyc(0, 0, 0, 0, 18'h2F0F1, 1);
    cyc(0, 0, 0, 1, 18'h0000F, 0);
    cyc(0, 0, 0, 2, 18'h3FFFF, 0);
    named("R2", 18'h2F0F1);
    foreach (pats[p]) begin
      cyc(0, 1, 1, 0, pats[p], 1);
      for (int m = 0; m < 4; m++)
        for (int a = 0; a < 4; a++)
          for (int s = 0; s < 4; s++)
            cyc(2'(m), s[0], s[1], 2'(a), ~pats[p], 0);
    end
    cyc(2, 0, 0, 0, 18'h3A5C7, 1);
    cyc(2, 0, 0, 0, 18'h11111, 0);
    cyc(2, 0, 0, 1, 18'h22222, 0);
    cyc(2, 0, 0, 1, 18'h05A5A, 1);
    cyc(2, 0, 0, 2, 18'h33333, 0);
    cyc(1, 0, 0, 2, 18'h0, 0);
    cyc(1, 0, 0, 3, 18'h0, 0);
    cyc(3, 0, 0, 0, 18'h0, 1);
    cyc(0, 0, 0, 1, 18'h0, 0);
    cyc(0, 1, 1, 0, 18'h0, 0);
    @(posedge clk);
    running = 0;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #200us;
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule